// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a management host reach a multi-device internal register space through a single bus address. A host write to a command register at offset 0 names an opcode, a target device and a register number. The bridge then runs the matching transfer on an internal register bus and raises a busy flag while the transfer is outstanding. For a write, the data comes from the data register at offset 1, which the host loads first. For a read, the result lands in the data register once busy drops. The host polls bit 15 of offset 0 and issues a new command only after it reads back zero.

A 5-bit strap input selects the mode. When the strap is non-zero, the block answers only host accesses whose bus address equals the strap, and it uses the command/data pair. When the strap is zero, the pair is bypassed. Each host access is then passed to the internal bus unchanged: the host bus address is the internal device and the host register number is the internal register. The serial management framing is not part of the block. The host side is a parallel request port that answers with an acknowledge pulse.

Top module: `smi_indirect_bridge`

## Requirements
- R1: After reset, busReq and hostAck are low, offset 0 reads 0x0000 and offset 1 reads 0x0000.
- R2: With a non-zero strap, a host access whose address differs from the strap changes no state. It is acknowledged one cycle after the request with read data 0xFFFF.
- R3: With a non-zero strap, writing offset 0 while idle with bits 15:10 = 100110 starts an internal read. busReq rises in the next cycle with busWe=0, busDev = bits 9:5 and busReg = bits 4:0.
- R4: Writing offset 0 while idle with bits 15:10 = 100101 starts an internal write of the current offset-1 contents to the device and register in bits 9:5 and 4:0.
- R5: Bit 15 of the offset-0 readback is 1 from the cycle after the command is accepted until the cycle after busAck. Bits 14:0 read back the last accepted command.
- R6: When an internal read completes, busRdata is stored in offset 1, and later reads of offset 1 return it.
- R7: An offset-0 write whose bits 15:10 match neither opcode is ignored. Busy stays 0, no bus request is made, and the readback is unchanged.
- R8: Writes to offset 1 while busy is set are ignored. Neither an in-flight read result nor the data being written is altered.
- R9: Writes to offset 0 while busy is set are ignored. No second transfer is started.
- R10: While busReq is high and busAck is low, busWe, busDev, busReg and busWdata hold steady. Each transfer keeps busReq high until the slave acknowledges.
- R11: With the strap at zero, a host access becomes an internal transfer with busDev = hostAddr, busReg = hostReg and the same direction and data. hostAck and hostRdata (read data) follow one cycle after busAck.
- R12: With a non-zero strap, accesses to the strap address are acknowledged one cycle after the request. Offsets other than 0 and 1 read 0xFFFF, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| strapAddr | input | 5 | Bus address strap; zero selects pass-through mode |
| hostReq | input | 1 | Host access request, sampled each cycle |
| hostWe | input | 1 | Host access is a write |
| hostAddr | input | 5 | Host bus address |
| hostReg | input | 5 | Host register number |
| hostWdata | input | 16 | Host write data |
| hostAck | output | 1 | One-cycle access acknowledge |
| hostRdata | output | 16 | Read data, valid with hostAck |
| busReq | output | 1 | Internal transfer request, held until busAck |
| busWe | output | 1 | Internal transfer is a write |
| busDev | output | 5 | Internal device address |
| busReg | output | 5 | Internal register number |
| busWdata | output | 16 | Internal write data |
| busAck | input | 1 | Internal slave completion |
| busRdata | input | 16 | Internal read data, valid with busAck |

## Verification
Register accesses at the strap address answer at the first falling edge after the sampling rising edge, so the bench reads hostAck and hostRdata there. An accepted command raises busReq one edge later. The internal slave model acknowledges after a fixed number of request cycles and records how long each request lasted, so the bench can check the request length exactly. The busy flag is checked on the first poll, which falls inside that window. A read result is checked only after a poll has seen busy clear. In pass-through mode the bench counts falling edges from request to acknowledge and expects exactly the slave latency.

// File: rtl/smi_bridge_pkg.sv
package smi_bridge_pkg;

  // Opcode field (command word bits 15:10)
  localparam logic [5:0] OPC_READ  = 6'b100110;
  localparam logic [5:0] OPC_WRITE = 6'b100101;

  typedef enum logic [1:0] {
    RD_CMD  = 2'd0,
    RD_DATA = 2'd1,
    RD_NONE = 2'd2,
    RD_BUS  = 2'd3
  } rdsel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   cmdLoad;
    logic   dataHostLoad;
    logic   dataBusLoad;
    logic   directLoad;
    logic   ackNow;
    rdsel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/smi_bridge_ctrl.sv
module smi_bridge_ctrl
  import smi_bridge_pkg::*;
#(
  parameter int DEV_W = 5,
  parameter int REG_W = 5,
  parameter int OPC_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DEV_W-1:0] strapAddr,
  input  logic             hostReq,
  input  logic             hostWe,
  input  logic [DEV_W-1:0] hostAddr,
  input  logic [REG_W-1:0] hostReg,
  input  logic [OPC_W-1:0] hostOpc,
  input  logic             busAck,
  input  logic             busWe,
  output strobe_t          strb,
  output logic             busy,
  output logic             busActive
);

  typedef enum logic [1:0] {S_IDLE, S_IND, S_DIR} state_e;

  state_e state, stateNext;
  logic directMode, addrHit, opcValid;

  assign directMode = (strapAddr == '0);
  assign addrHit    = (hostAddr == strapAddr);
  assign opcValid   = (hostOpc == OPC_READ) || (hostOpc == OPC_WRITE);
  assign busy       = (state == S_IND);
  assign busActive  = (state != S_IDLE);

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    stateNext  = state;
    if (hostReq) begin
      if (directMode) begin
        if (!busActive) begin
          strb.directLoad = 1'b1;
          stateNext       = S_DIR;
        end
      end else begin
        strb.ackNow = 1'b1;
        if (addrHit && hostReg == REG_W'(0)) begin
          strb.rdSel = RD_CMD;
          if (hostWe && !busActive && opcValid) begin
            strb.cmdLoad = 1'b1;
            stateNext    = S_IND;
          end
        end else if (addrHit && hostReg == REG_W'(1)) begin
          strb.rdSel = RD_DATA;
          if (hostWe && !busActive) strb.dataHostLoad = 1'b1;
        end
      end
    end
    if (busActive && busAck) begin
      stateNext = S_IDLE;
      if (!busWe) strb.dataBusLoad = 1'b1;
      if (state == S_DIR) begin
        strb.ackNow = 1'b1;
        strb.rdSel  = RD_BUS;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  // R7: a malformed command leaves the bridge idle
  p_bad_opc_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && hostWe && !directMode && addrHit && hostReg == REG_W'(0)
     && !opcValid && !busActive) |=> !busActive);

  // R5: busy drops in the cycle after the slave acknowledges
  p_busy_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busAck) |=> !busy);

  // R9: command writes during busy start nothing new
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !busAck) |=> busy);

endmodule

// File: rtl/smi_bridge_dpath.sv
module smi_bridge_dpath
  import smi_bridge_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              busy,
  input  logic              busActive,
  input  logic              busAck,
  input  logic              hostWe,
  input  logic [DEV_W-1:0]  hostAddr,
  input  logic [REG_W-1:0]  hostReg,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              hostAck,
  output logic [DATA_W-1:0] hostRdata,
  output logic              busWe,
  output logic [DEV_W-1:0]  busDev,
  output logic [REG_W-1:0]  busReg,
  output logic [DATA_W-1:0] busWdata
);

  localparam int OPC_W = DATA_W - DEV_W - REG_W;

  logic [DATA_W-2:0] cmdLow;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] rdMux;
  logic [OPC_W-1:0]  opcIn;

  assign opcIn    = hostWdata[DATA_W-1 -: OPC_W];
  assign busWdata = dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdLow  <= '0;
      busWe   <= 1'b0;
      busDev  <= '0;
      busReg  <= '0;
    end else if (strb.cmdLoad) begin
      cmdLow  <= hostWdata[DATA_W-2:0];
      busWe   <= (opcIn == OPC_WRITE);
      busDev  <= hostWdata[DEV_W+REG_W-1:REG_W];
      busReg  <= hostWdata[REG_W-1:0];
    end else if (strb.directLoad) begin
      busWe   <= hostWe;
      busDev  <= hostAddr;
      busReg  <= hostReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                  dataReg <= '0;
    else if (strb.dataBusLoad)                  dataReg <= busRdata;
    else if (strb.dataHostLoad)                 dataReg <= hostWdata;
    else if (strb.directLoad && hostWe)         dataReg <= hostWdata;
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_CMD:  rdMux = {busy, cmdLow};
      RD_DATA: rdMux = dataReg;
      RD_BUS:  rdMux = busRdata;
      default: rdMux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostAck   <= 1'b0;
      hostRdata <= '0;
    end else begin
      hostAck <= strb.ackNow;
      if (strb.ackNow) hostRdata <= rdMux;
    end
  end

  // R8: offset 1 is frozen while a transfer is outstanding
  p_data_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busActive && !busAck) |=> $stable(dataReg));

  // R10: request fields hold until acknowledged
  p_fields_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busActive && !busAck) |=> ($stable(busWe) && $stable(busDev) && $stable(busReg)));

endmodule

// File: rtl/smi_indirect_bridge.sv
module smi_indirect_bridge
  import smi_bridge_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DEV_W-1:0]  strapAddr,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [DEV_W-1:0]  hostAddr,
  input  logic [REG_W-1:0]  hostReg,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostAck,
  output logic [DATA_W-1:0] hostRdata,
  output logic              busReq,
  output logic              busWe,
  output logic [DEV_W-1:0]  busDev,
  output logic [REG_W-1:0]  busReg,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRdata
);

  localparam int OPC_W = DATA_W - DEV_W - REG_W;

  strobe_t strb;
  logic    busy;
  logic    busActive;

  smi_bridge_ctrl #(.DEV_W(DEV_W), .REG_W(REG_W), .OPC_W(OPC_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .strapAddr (strapAddr),
    .hostReq   (hostReq),
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostReg   (hostReg),
    .hostOpc   (hostWdata[DATA_W-1 -: OPC_W]),
    .busAck    (busAck),
    .busWe     (busWe),
    .strb      (strb),
    .busy      (busy),
    .busActive (busActive)
  );

  smi_bridge_dpath #(.DEV_W(DEV_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busy      (busy),
    .busActive (busActive),
    .busAck    (busAck),
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostReg   (hostReg),
    .hostWdata (hostWdata),
    .busRdata  (busRdata),
    .hostAck   (hostAck),
    .hostRdata (hostRdata),
    .busWe     (busWe),
    .busDev    (busDev),
    .busReg    (busReg),
    .busWdata  (busWdata)
  );

  assign busReq = busActive;

  // R3: an accepted read command launches the bus read next cycle
  p_cmd_launch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && hostWe && strapAddr != '0 && hostAddr == strapAddr &&
     hostReg == REG_W'(0) && hostWdata[DATA_W-1 -: OPC_W] == OPC_READ && !busReq)
    |=> (busReq && !busWe && busDev == $past(hostWdata[DEV_W+REG_W-1:REG_W]) &&
         busReg == $past(hostWdata[REG_W-1:0])));

  // R2: foreign addresses answer with all ones
  p_foreign_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && strapAddr != '0 && hostAddr != strapAddr) |=> (hostAck && hostRdata == '1));

  // R11: pass-through acknowledge follows the slave by one cycle
  p_direct_ack_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strapAddr == '0 && busReq && busAck) |=> (hostAck && hostRdata == $past(busRdata)));

endmodule

// File: tb/smi_indirect_bridge_tb_top.sv
`timescale 1ns/1ps
module smi_indirect_bridge_tb_top;

  localparam int LAT = 4;
  localparam logic [4:0] STRAP = 5'd17;
  localparam logic [5:0] OP_RD = 6'b100110;
  localparam logic [5:0] OP_WR = 6'b100101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] strapAddr = STRAP;
  logic hostReq = 1'b0, hostWe = 1'b0;
  logic [4:0] hostAddr = '0, hostReg = '0;
  logic [15:0] hostWdata = '0;
  logic hostAck;
  logic [15:0] hostRdata;
  logic busReq, busWe;
  logic [4:0] busDev, busReg;
  logic [15:0] busWdata;
  logic busAck = 1'b0;
  logic [15:0] busRdata = '0;

  always #2.5 clk = ~clk;

  smi_indirect_bridge dut_i (
    .clk(clk), .rstN(rstN), .strapAddr(strapAddr),
    .hostReq(hostReq), .hostWe(hostWe), .hostAddr(hostAddr), .hostReg(hostReg),
    .hostWdata(hostWdata), .hostAck(hostAck), .hostRdata(hostRdata),
    .busReq(busReq), .busWe(busWe), .busDev(busDev), .busReg(busReg),
    .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata)
  );

  int nChecks = 0, nFail = 0;
  logic [15:0] mem [1024];
  logic [15:0] expMem [1024];
  int txnCount = 0, lastLen = 0;
  logic lastWe;
  logic [4:0] lastDev, lastReg;
  logic [15:0] lastWdata;
  logic [15:0] lastRd;
  int lastLat;

  function automatic logic [15:0] initVal(int i);
    return 16'(i * 40503) ^ 16'h5a5a;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Internal slave: acknowledges after LAT request cycles
  initial begin
    int cnt = 0;
    for (int i = 0; i < 1024; i++) mem[i] = initVal(i);
    forever begin
      @(negedge clk);
      if (busAck) begin
        busAck = 1'b0;
        cnt = 0;
      end else if (busReq) begin
        cnt++;
        if (cnt == LAT) begin
          if (busWe) mem[{busDev, busReg}] = busWdata;
          else busRdata = mem[{busDev, busReg}];
          lastWe = busWe; lastDev = busDev; lastReg = busReg;
          lastWdata = busWdata; lastLen = cnt;
          txnCount++;
          busAck = 1'b1;
        end
      end
    end
  end

  task automatic hostXfer(input logic we, input logic [4:0] a, input logic [4:0] r,
                          input logic [15:0] wd);
    int n = 0;
    @(negedge clk);
    hostReq = 1'b1; hostWe = we; hostAddr = a; hostReg = r; hostWdata = wd;
    @(negedge clk);
    hostReq = 1'b0;
    while (!hostAck && n < 100) begin
      @(negedge clk);
      n++;
    end
    lastRd = hostRdata;
    lastLat = n;
  endtask

  task automatic pollIdle(output int polls, output logic [15:0] firstRd);
    polls = 0;
    do begin
      hostXfer(1'b0, STRAP, 5'd0, 16'h0);
      if (polls == 0) firstRd = lastRd;
      polls++;
    end while (lastRd[15] && polls < 50);
  endtask

  task automatic indRead(input logic [4:0] d, input logic [4:0] r, input bit junk);
    int polls; logic [15:0] first; logic [15:0] cmd;
    cmd = {OP_RD, d, r};
    hostXfer(1'b1, STRAP, 5'd0, cmd);
    chk("R3 busReq after read command", busReq, 1'b1);
    if (junk) hostXfer(1'b1, STRAP, 5'd1, 16'hDEAD);
    pollIdle(polls, first);
    chk("R5 busy on first poll", first[15], 1'b1);
    chk("R5 command readback", first[14:0], cmd[14:0]);
    chk("R3 bus read fields", {lastWe, lastDev, lastReg}, {1'b0, d, r});
    chk("R10 request length", lastLen, LAT);
    hostXfer(1'b0, STRAP, 5'd1, 16'h0);
    chk(junk ? "R8 read result kept" : "R6 read result", lastRd, expMem[{d, r}]);
  endtask

  task automatic indWrite(input logic [4:0] d, input logic [4:0] r, input logic [15:0] v,
                          input bit junk);
    int polls; logic [15:0] first;
    hostXfer(1'b1, STRAP, 5'd1, v);
    hostXfer(1'b1, STRAP, 5'd0, {OP_WR, d, r});
    if (junk) hostXfer(1'b1, STRAP, 5'd1, ~v);
    pollIdle(polls, first);
    chk("R4 bus write fields", {lastWe, lastDev, lastReg}, {1'b1, d, r});
    chk(junk ? "R8 write data kept" : "R4 write data", lastWdata, v);
    expMem[{d, r}] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [15:0] snap, cmdSnap;
    int t0;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 1024; i++) expMem[i] = initVal(i);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busReq after reset", busReq, 1'b0);
    chk("R1 hostAck after reset", hostAck, 1'b0);
    hostXfer(1'b0, STRAP, 5'd0, 16'h0);
    chk("R1 command reads zero", lastRd, 16'h0000);
    chk("R12 indirect ack latency", lastLat, 0);
    hostXfer(1'b0, STRAP, 5'd1, 16'h0);
    chk("R1 data reads zero", lastRd, 16'h0000);

    // R2: foreign address
    hostXfer(1'b1, STRAP ^ 5'd1, 5'd1, 16'h1234);
    chk("R2 foreign write ack data", lastRd, 16'hFFFF);
    chk("R2 foreign ack latency", lastLat, 0);
    hostXfer(1'b1, STRAP ^ 5'd4, 5'd0, {OP_RD, 5'd2, 5'd3});
    chk("R2 foreign command no bus", busReq, 1'b0);
    hostXfer(1'b0, STRAP, 5'd1, 16'h0);
    chk("R2 data unchanged", lastRd, 16'h0000);

    // R12: other offsets
    hostXfer(1'b0, STRAP, 5'd2, 16'h0);
    chk("R12 offset 2 reads ones", lastRd, 16'hFFFF);
    hostXfer(1'b1, STRAP, 5'd3, 16'hBEEF);
    hostXfer(1'b0, STRAP, 5'd1, 16'h0);
    chk("R12 offset 3 write no effect", lastRd, 16'h0000);

    // Directed read / write
    indRead(5'd0, 5'd0, 1'b0);
    indWrite(5'd31, 5'd31, 16'hA5C3, 1'b0);
    indRead(5'd31, 5'd31, 1'b0);

    // R7: malformed opcodes
    hostXfer(1'b0, STRAP, 5'd0, 16'h0);
    cmdSnap = lastRd;
    t0 = txnCount;
    for (int k = 0; k < 6; k++) begin
      logic [5:0] op;
      do op = 6'($urandom); while (op == OP_RD || op == OP_WR);
      hostXfer(1'b1, STRAP, 5'd0, {op, 10'($urandom)});
      chk("R7 bad opcode no request", busReq, 1'b0);
    end
    hostXfer(1'b0, STRAP, 5'd0, 16'h0);
    chk("R7 readback unchanged", lastRd, cmdSnap);
    chk("R7 no transfer", txnCount, t0);

    // R9: command while busy
    t0 = txnCount;
    begin
      int polls; logic [15:0] first;
      hostXfer(1'b1, STRAP, 5'd0, {OP_RD, 5'd3, 5'd4});
      hostXfer(1'b1, STRAP, 5'd0, {OP_WR, 5'd9, 5'd9});
      pollIdle(polls, first);
      repeat (LAT + 2) @(negedge clk);
      chk("R9 single transfer", txnCount, t0 + 1);
      chk("R9 first command kept", {lastWe, lastDev, lastReg}, {1'b0, 5'd3, 5'd4});
      hostXfer(1'b0, STRAP, 5'd0, 16'h0);
      chk("R9 readback of first command", lastRd, {1'b0, OP_RD[4:0], 5'd3, 5'd4});
      hostXfer(1'b0, STRAP, 5'd1, 16'h0);
      chk("R6 result of first command", lastRd, expMem[{5'd3, 5'd4}]);
    end

    // Random indirect traffic
    for (int k = 0; k < 60; k++) begin
      logic [4:0] d, r;
      d = 5'($urandom); r = 5'($urandom);
      if ($urandom_range(0, 1) == 0) indRead(d, r, ($urandom_range(0, 3) == 0));
      else indWrite(d, r, 16'($urandom), ($urandom_range(0, 3) == 0));
    end

    // R11: pass-through mode
    @(negedge clk);
    strapAddr = 5'd0;
    for (int k = 0; k < 30; k++) begin
      logic [4:0] d, r; logic [15:0] v;
      d = 5'($urandom); r = 5'($urandom); v = 16'($urandom);
      if ($urandom_range(0, 1) == 0) begin
        hostXfer(1'b0, d, r, 16'h0);
        chk("R11 direct read data", lastRd, expMem[{d, r}]);
        chk("R11 direct read fields", {lastWe, lastDev, lastReg}, {1'b0, d, r});
      end else begin
        hostXfer(1'b1, d, r, v);
        chk("R11 direct write fields", {lastWe, lastDev, lastReg, lastWdata}, {1'b1, d, r, v});
        expMem[{d, r}] = v;
      end
      chk("R11 direct ack latency", lastLat, LAT);
    end

    // Back to indirect, confirm direct writes landed
    @(negedge clk);
    strapAddr = STRAP;
    snap = expMem[{5'd31, 5'd31}];
    indRead(5'd31, 5'd31, 1'b0);
    chk("R6 final readback", lastRd, snap);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule